// File: doc/BRIEF.md
# Drum Sector Transfer Engine

This block is the command side and the word mover of a serial drum controller attached to an 18-bit processor. The processor reaches it through programmed I/O. A command strobe carries a device selector (one of three codes), a six-bit pulse field and the accumulator. Through these commands software sets up a 16-bit memory pointer and a transfer direction, chooses a sector, starts or restarts the transfer, tests the completion and error flags for a skip, and clears those flags.

A start raises `start_req` for one cycle so that an external rotation scheduler can wait for the right sector. The scheduler then pulses `sector_start`. The engine moves one sector of 256 words between the memory port and the external drum array. After the last word it steps the sector number and raises `irq`. A 32-bit write-lock mask protects the drum in groups of sixteen sectors.

The memory port is valid/ready. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_we` hold their values. A word counts as moved only in a cycle where both are high, and at most one word moves per cycle. The drum array reads asynchronously: `drum_rdata` must follow `drum_addr` within the same cycle. It writes at the clock edge when `drum_we` is high.

Top module: `drum_xfer_engine`

## Requirements
- R1: On selector 0, a pulse field whose bits 4, 2, 1, 0 equal 0,1,1,0 (field & 0o27 == 0o06) loads the memory pointer from accumulator bits 15:0 and latches the direction from pulse bit 5 (1 = drum write, 0 = drum read). Any other pulse field on selector 0 changes neither.
- R2: On selector 1, pulse bit 0 drives `iot_skip` high in the same cycle when done is set. Pulse bit 1 clears done and error. Pulse bit 2 loads the sector number from accumulator bits 8:0, raises `start_req` for that cycle and arms the engine. The transfer begins at the next `sector_start`.
- R3: On selector 2, pulse bit 0 drives `iot_skip` high when error is clear. Pulse bit 2 clears done and error and restarts a transfer on the sector number already held.
- R4: A transfer covers 256 words. Word i uses drum address sector×256+i. The memory pointer advances by one, modulo 65536, after each word.
- R5: In a drum write, if bit (sector >> 4) of `wlock` is set, `drum_we` stays low for every word and error is set. The memory pointer still advances as for an unlocked write.
- R6: After word 255 the sector number increments modulo 512 and done is set. `irq` shows done.
- R7: Reset clears the sector number, memory pointer, done and error, and abandons an armed or running transfer.
- R8: A start while `drum_present` is low sets done and error in the next cycle, gives no `start_req`, and moves no words.
- R9: In a drum read, a word whose memory address is at or above MEM_WORDS (default 32768) is dropped without a memory beat, but it still consumes its drum word and one pointer step.
- R10: When a flag clear and the completion of word 255 fall in the same cycle, done ends that cycle set.
- R11: A memory request held without `mem_ready` keeps `mem_valid`, `mem_addr` and `mem_we` unchanged in the next cycle. Each word needs one accepted beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iot_valid | input | 1 | Command strobe, one cycle per command |
| iot_dev | input | 2 | Device selector 0, 1 or 2 |
| iot_pulse | input | 6 | Pulse field of the command |
| iot_acc | input | 18 | Accumulator value |
| iot_skip | output | 1 | Skip request for the current command |
| irq | output | 1 | Done flag, used as interrupt request |
| err_flag | output | 1 | Error flag |
| start_req | output | 1 | One-cycle request to the rotation scheduler |
| sector_start | input | 1 | Scheduler pulse: target sector under the heads |
| drum_present | input | 1 | Drum storage attached |
| wlock | input | 32 | Write-lock mask, one bit per 16 sectors |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = memory write (drum read) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 18 | Word written to memory |
| mem_rdata | input | 18 | Word read from memory, valid with mem_ready |
| drum_re | output | 1 | Drum read in progress |
| drum_we | output | 1 | Drum write strobe |
| drum_addr | output | 17 | Drum word address |
| drum_wdata | output | 18 | Word written to the drum |
| drum_rdata | input | 18 | Word read from the drum (asynchronous) |

## Verification
The risky overlap is a flag-clear command in the same cycle as the final word of a sector. The clear wants done low, and completion wants it high. The bench holds `mem_ready` under its own control and counts accepted beats. In the cycle where the 256th beat is offered, it issues the clear on selector 1. In the next cycle `irq` must read 1, and a later clear must still bring it to 0. A second overlap, a command load during back-pressure, is kept out of the hold property's antecedent so that the property judges only undisturbed requests.

// File: rtl/drum_pkg.sv
package drum_pkg;
  localparam int PULSE_W = 6;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_SECT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [PULSE_W-1:0] LD_MASK  = 6'o27;
  localparam logic [PULSE_W-1:0] LD_MATCH = 6'o06;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2
  } xfer_state_t;

  typedef struct packed {
    logic ld_addr;
    logic fn_write;
    logic ld_sec;
    logic start;
    logic clr;
  } iot_cmd_t;
endpackage

// File: rtl/drum_iot_decode.sv
module drum_iot_decode
  import drum_pkg::*;
(
  input  logic               iot_valid,
  input  logic [1:0]         iot_dev,
  input  logic [PULSE_W-1:0] iot_pulse,
  input  logic               done,
  input  logic               err,
  output iot_cmd_t           cmd,
  output logic               skip
);
  logic sel_a, sel_s, sel_c;

  always_comb begin
    sel_a = iot_valid && (iot_dev == SEL_ADDR);
    sel_s = iot_valid && (iot_dev == SEL_SECT);
    sel_c = iot_valid && (iot_dev == SEL_CTRL);

    cmd.ld_addr  = sel_a && ((iot_pulse & LD_MASK) == LD_MATCH);
    cmd.fn_write = iot_pulse[5];
    cmd.ld_sec   = sel_s && iot_pulse[2];
    cmd.start    = (sel_s || sel_c) && iot_pulse[2];
    cmd.clr      = (sel_s && iot_pulse[1]) || (sel_c && iot_pulse[2]);

    skip = (sel_s && iot_pulse[0] && done) ||
           (sel_c && iot_pulse[0] && !err);
  end
endmodule

// File: rtl/drum_xfer_seq.sv
module drum_xfer_seq
  import drum_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int MA_W      = 16,
  parameter int SEC_W     = 9,
  parameter int WIDX_W    = 8,
  parameter int LOCK_W    = 32,
  parameter int MEM_WORDS = 32768
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  iot_cmd_t                cmd,
  input  logic [WORD_W-1:0]       acc,
  input  logic                    sector_start,
  input  logic                    drum_present,
  input  logic [LOCK_W-1:0]       wlock,
  output logic                    done,
  output logic                    err,
  output logic                    start_req,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [MA_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    drum_re,
  output logic                    drum_we,
  output logic [SEC_W+WIDX_W-1:0] drum_addr,
  output logic [WORD_W-1:0]       drum_wdata,
  input  logic [WORD_W-1:0]       drum_rdata
);
  localparam int GRP_LSB = SEC_W - $clog2(LOCK_W);
  localparam logic [MA_W:0] MEM_LIM = (MEM_WORDS)'(MA_W + 1)'(MEM_WORDS);

  xfer_state_t       st;
  logic [MA_W-1:0]   ma;
  logic [SEC_W-1:0]  sec;
  logic [WIDX_W-1:0] widx;
  logic              fn_wr;

  logic in_xfer, ma_ok, locked, step, fin, lock_hit, start_ok, start_bad;

  always_comb begin
    in_xfer   = (st == ST_XFER);
    ma_ok     = ({1'b0, ma} < MEM_LIM);
    locked    = wlock[sec[SEC_W-1:GRP_LSB]];
    start_ok  = cmd.start && drum_present;
    start_bad = cmd.start && !drum_present;

    mem_valid  = in_xfer && (fn_wr || ma_ok);
    mem_we     = !fn_wr;
    mem_addr   = ma;
    mem_wdata  = drum_rdata;
    drum_addr  = {sec, widx};
    drum_re    = in_xfer && !fn_wr;
    drum_we    = in_xfer && fn_wr && mem_ready && !locked;
    drum_wdata = mem_rdata;

    step     = in_xfer && (mem_valid ? mem_ready : 1'b1);
    fin      = step && (&widx);
    lock_hit = step && fn_wr && locked;
    start_req = start_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma    <= '0;
      fn_wr <= 1'b0;
    end else if (cmd.ld_addr) begin
      ma    <= acc[MA_W-1:0];
      fn_wr <= cmd.fn_write;
    end else if (step) begin
      ma <= ma + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sec <= '0;
    else if (cmd.ld_sec) sec <= acc[SEC_W-1:0];
    else if (fin)        sec <= sec + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      widx <= '0;
    end else if (start_ok) begin
      st   <= ST_ARMED;
      widx <= '0;
    end else if (start_bad) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_ARMED: if (sector_start) begin
          st   <= ST_XFER;
          widx <= '0;
        end
        ST_XFER: if (step) begin
          widx <= widx + 1'b1;
          if (&widx) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (fin || start_bad) done <= 1'b1;
      else if (cmd.clr)     done <= 1'b0;
      if (lock_hit || start_bad) err <= 1'b1;
      else if (cmd.clr)          err <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cmd.ld_addr && !cmd.start)
      |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  p_ma_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cmd.ld_addr) |=> (ma == $past(ma) + 1'b1));

  p_lock_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit |=> err);

  p_sec_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !cmd.ld_sec) |=> (sec == $past(sec) + 1'b1));

  p_done_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done);

  p_nodrum_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (done && err && st == ST_IDLE));

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (st == ST_ARMED));
endmodule

// File: rtl/drum_xfer_engine.sv
module drum_xfer_engine
  import drum_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int MA_W      = 16,
  parameter int SEC_W     = 9,
  parameter int WIDX_W    = 8,
  parameter int LOCK_W    = 32,
  parameter int MEM_WORDS = 32768
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iot_valid,
  input  logic [1:0]              iot_dev,
  input  logic [5:0]              iot_pulse,
  input  logic [WORD_W-1:0]       iot_acc,
  output logic                    iot_skip,
  output logic                    irq,
  output logic                    err_flag,
  output logic                    start_req,
  input  logic                    sector_start,
  input  logic                    drum_present,
  input  logic [LOCK_W-1:0]       wlock,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [MA_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    drum_re,
  output logic                    drum_we,
  output logic [SEC_W+WIDX_W-1:0] drum_addr,
  output logic [WORD_W-1:0]       drum_wdata,
  input  logic [WORD_W-1:0]       drum_rdata
);
  iot_cmd_t cmd;
  logic     done_w, err_w;

  drum_iot_decode u_dec (
    .iot_valid (iot_valid),
    .iot_dev   (iot_dev),
    .iot_pulse (iot_pulse),
    .done      (done_w),
    .err       (err_w),
    .cmd       (cmd),
    .skip      (iot_skip)
  );

  drum_xfer_seq #(
    .WORD_W(WORD_W), .MA_W(MA_W), .SEC_W(SEC_W), .WIDX_W(WIDX_W),
    .LOCK_W(LOCK_W), .MEM_WORDS(MEM_WORDS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .acc          (iot_acc),
    .sector_start (sector_start),
    .drum_present (drum_present),
    .wlock        (wlock),
    .done         (done_w),
    .err          (err_w),
    .start_req    (start_req),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .drum_re      (drum_re),
    .drum_we      (drum_we),
    .drum_addr    (drum_addr),
    .drum_wdata   (drum_wdata),
    .drum_rdata   (drum_rdata)
  );

  assign irq      = done_w;
  assign err_flag = err_w;

  p_skip_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iot_skip |-> (iot_valid && iot_pulse[0]));
endmodule

// File: tb/sim_drum_xfer_engine.sv
module sim_drum_xfer_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [1:0]  iot_dev = 2'd0;
  logic [5:0]  iot_pulse = 6'd0;
  logic [17:0] iot_acc = 18'd0;
  logic        iot_skip, irq, err_flag, start_req;
  logic        sector_start = 1'b0;
  logic        drum_present = 1'b1;
  logic [31:0] wlock = 32'd0;
  logic        mem_valid, mem_ready, mem_we;
  logic [15:0] mem_addr;
  logic [17:0] mem_wdata, mem_rdata;
  logic        drum_re, drum_we;
  logic [16:0] drum_addr;
  logic [17:0] drum_wdata, drum_rdata;

  int checks = 0;
  int fails  = 0;

  logic [1:0] rdy_mode = 2'd0;
  logic       rdy_man  = 1'b1;
  logic       tick     = 1'b0;

  logic [8:0]  mon_sec  = '0;
  logic [15:0] mon_ma0  = '0;
  logic        mon_wr   = 1'b0;
  logic        mon_lock = 1'b0;
  int mon_beats = 0, mon_bad = 0, mon_dwr = 0, hold_bad = 0;
  logic        hold_pend = 1'b0;
  logic [15:0] hold_addr = '0;
  logic        last_start, last_skip;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] dpat(input logic [16:0] a);
    return {1'b1, a} ^ 18'h15A3C;
  endfunction
  function automatic logic [17:0] mpat(input logic [15:0] a);
    return {2'b01, a} ^ 18'h2C0F1;
  endfunction

  assign drum_rdata = dpat(drum_addr);
  assign mem_rdata  = mpat(mem_addr);
  assign mem_ready  = (rdy_mode == 2'd0) ? 1'b1 : (rdy_mode == 2'd1) ? tick : rdy_man;

  always @(negedge clk) tick <= ~tick;

  drum_xfer_engine u0 (.*);

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (hold_pend && (!mem_valid || mem_addr != hold_addr)) hold_bad++;
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
      if (drum_we) mon_dwr++;
      if (mem_valid && mem_ready) begin
        logic [15:0] idx;
        logic [16:0] exp_da;
        idx    = mem_addr - mon_ma0;
        exp_da = {mon_sec, idx[7:0]};
        if (idx > 16'd255 || drum_addr != exp_da || mem_we == mon_wr) mon_bad++;
        if (!mon_wr && mem_wdata != dpat(exp_da)) mon_bad++;
        if (mon_wr && (drum_we == mon_lock || (drum_we && drum_wdata != mpat(mem_addr)))) mon_bad++;
        mon_beats++;
      end
    end else begin
      hold_pend = 1'b0;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic iot(input logic [1:0] d, input logic [5:0] p, input logic [17:0] a);
    @(negedge clk);
    iot_valid = 1'b1; iot_dev = d; iot_pulse = p; iot_acc = a;
    #1;
    last_start = start_req;
    last_skip  = iot_skip;
    @(negedge clk);
    iot_valid = 1'b0; iot_pulse = '0;
  endtask

  task automatic arm_mon(input logic [8:0] s, input logic [15:0] m, input logic w, input logic l);
    mon_sec = s; mon_ma0 = m; mon_wr = w; mon_lock = l;
    mon_beats = 0; mon_bad = 0; mon_dwr = 0; hold_bad = 0;
  endtask

  task automatic run_xfer(input logic [8:0] s, input logic [15:0] m, input logic w, input logic l);
    arm_mon(s, m, w, l);
    sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    #2;
    check(irq == 1'b1, "R6 done after sector", irq, 1);
  endtask

  task automatic t_reset;
    check(irq == 1'b0 && err_flag == 1'b0, "R7 flags after reset", {irq, err_flag}, 0);
    check(mem_valid == 1'b0, "R7 no memory request after reset", mem_valid, 0);
    iot(2'd2, 6'o01, '0);
    check(last_skip == 1'b1, "R3 skip when error clear", last_skip, 1);
    iot(2'd1, 6'o01, '0);
    check(last_skip == 1'b0, "R2 no skip when done clear", last_skip, 0);
  endtask

  task automatic t_read_basic;
    iot(2'd0, 6'o06, 18'h3_0100);
    iot(2'd1, 6'o04, 18'h3_FE05);
    check(last_start == 1'b1, "R2 start_req on sector load", last_start, 1);
    run_xfer(9'h005, 16'h0100, 1'b0, 1'b0);
    check(mon_beats == 256, "R4 word count", mon_beats, 256);
    check(mon_bad == 0, "R4 addresses and data", mon_bad, 0);
    iot(2'd1, 6'o01, '0);
    check(last_skip == 1'b1, "R2 skip when done set", last_skip, 1);
  endtask

  task automatic t_restart;
    iot(2'd2, 6'o04, '0);
    check(irq == 1'b0, "R3 restart clears done", irq, 0);
    run_xfer(9'h006, 16'h0200, 1'b0, 1'b0);
    check(mon_beats == 256 && mon_bad == 0, "R3 restart on next sector", mon_bad, 0);
  endtask

  task automatic t_decode_mask;
    iot(2'd0, 6'o47, 18'h0_4444);
    iot(2'd1, 6'o02, '0);
    check(irq == 1'b0, "R2 clear command drops done", irq, 0);
    iot(2'd2, 6'o04, '0);
    run_xfer(9'h007, 16'h0300, 1'b0, 1'b0);
    check(mon_beats == 256 && mon_bad == 0, "R1 non-matching pulse ignored", mon_bad, 0);
  endtask

  task automatic t_wrap_suppress;
    iot(2'd0, 6'o06, 18'h0_FFF0);
    iot(2'd2, 6'o04, '0);
    run_xfer(9'h008, 16'hFFF0, 1'b0, 1'b0);
    check(mon_beats == 240, "R9 out-of-range words dropped", mon_beats, 240);
    check(mon_bad == 0, "R4 pointer wraps at 65536", mon_bad, 0);
  endtask

  task automatic t_write_lock;
    wlock = 32'h0000_0002;
    iot(2'd0, 6'o46, 18'h0_1000);
    iot(2'd1, 6'o02, '0);
    iot(2'd1, 6'o04, 18'h0_0015);
    run_xfer(9'h015, 16'h1000, 1'b1, 1'b1);
    check(mon_dwr == 0, "R5 locked write stores nothing", mon_dwr, 0);
    check(mon_beats == 256 && mon_bad == 0, "R5 locked write still steps", mon_bad, 0);
    check(err_flag == 1'b1, "R5 error on locked write", err_flag, 1);
    iot(2'd2, 6'o01, '0);
    check(last_skip == 1'b0, "R3 no skip while error set", last_skip, 0);
    iot(2'd1, 6'o02, '0);
    check(err_flag == 1'b0, "R2 clear drops error", err_flag, 0);
    iot(2'd1, 6'o04, 18'h0_0025);
    run_xfer(9'h025, 16'h1100, 1'b1, 1'b0);
    check(mon_dwr == 256 && mon_bad == 0, "R5 unlocked group writes", mon_dwr, 256);
    check(err_flag == 1'b0, "R5 no error when unlocked", err_flag, 0);
    wlock = 32'd0;
  endtask

  task automatic t_backpressure;
    rdy_mode = 2'd1;
    iot(2'd0, 6'o06, 18'h0_2000);
    iot(2'd1, 6'o02, '0);
    iot(2'd1, 6'o04, 18'h0_01FF);
    run_xfer(9'h1FF, 16'h2000, 1'b0, 1'b0);
    check(mon_beats == 256 && mon_bad == 0, "R11 stalled transfer intact", mon_bad, 0);
    check(hold_bad == 0, "R11 request held while not ready", hold_bad, 0);
    iot(2'd2, 6'o04, '0);
    run_xfer(9'h000, 16'h2100, 1'b0, 1'b0);
    check(mon_beats == 256 && mon_bad == 0, "R6 sector wraps 511 to 0", mon_bad, 0);
    rdy_mode = 2'd0;
  endtask

  task automatic t_no_drum;
    drum_present = 1'b0;
    iot(2'd1, 6'o02, '0);
    iot(2'd1, 6'o04, 18'h0_0030);
    check(last_start == 1'b0, "R8 no start_req without drum", last_start, 0);
    check(irq == 1'b1 && err_flag == 1'b1, "R8 done and error set", {irq, err_flag}, 3);
    arm_mon(9'h030, 16'h2200, 1'b0, 1'b0);
    sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    repeat (5) @(negedge clk);
    check(mon_beats == 0, "R8 no words moved", mon_beats, 0);
    drum_present = 1'b1;
    iot(2'd1, 6'o02, '0);
  endtask

  task automatic t_collision;
    iot(2'd0, 6'o06, 18'h0_3000);
    iot(2'd1, 6'o04, 18'h0_0040);
    arm_mon(9'h040, 16'h3000, 1'b0, 1'b0);
    rdy_mode = 2'd2; rdy_man = 1'b1;
    sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    for (int i = 0; i < 600 && mon_beats != 255; i++) @(negedge clk);
    iot_valid = 1'b1; iot_dev = 2'd1; iot_pulse = 6'o02;
    @(negedge clk);
    iot_valid = 1'b0; iot_pulse = '0;
    #2;
    check(irq == 1'b1, "R10 completion beats same-cycle clear", irq, 1);
    check(mon_beats == 256, "R10 final word moved", mon_beats, 256);
    iot(2'd1, 6'o02, '0);
    check(irq == 1'b0, "R10 later clear drops done", irq, 0);
    rdy_mode = 2'd0;
  endtask

  task automatic t_reset_abort;
    iot(2'd0, 6'o06, 18'h0_4000);
    iot(2'd1, 6'o04, 18'h0_0050);
    arm_mon(9'h050, 16'h4000, 1'b0, 1'b0);
    sector_start = 1'b1;
    @(negedge clk);
    sector_start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(mem_valid == 1'b0 && irq == 1'b0, "R7 reset abandons transfer", mem_valid, 0);
    iot(2'd2, 6'o04, '0);
    run_xfer(9'h000, 16'h0000, 1'b0, 1'b0);
    check(mon_beats == 256 && mon_bad == 0, "R7 sector and pointer cleared", mon_bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_basic;
    t_restart;
    t_decode_mask;
    t_wrap_suppress;
    t_write_lock;
    t_backpressure;
    t_no_drum;
    t_collision;
    t_reset_abort;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule